// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers eight interrupt request lines into one CPU interrupt. The lines have fixed priorities: line 0 (serial receive) is the most urgent, followed by line 1 (vertical retrace), line 2 (periodic timer), and then lines 3 to 7 in numeric order. A rising edge on a line marks it pending. The line stays pending until the CPU acknowledges it. The controller drives the interrupt output and a 3-bit code that names the winning line.

Software controls acceptance through two registers written over a small write port.

- **Level register**
  - In compare mode it holds a threshold. Only lines whose number is below the threshold may interrupt.
  - In priority mode the threshold is ignored. The lowest-numbered eligible pending line wins.
- **Enable register**
  - It gates only the three internal sources (lines 0 to 2).

Each acknowledge does two things. It clears the reported line. It also loads that line's number into the threshold, so equal and lower priorities stay blocked until software writes the level register again.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, irq_o and irq_lvl_o are 0. The threshold is 0, compare mode is selected, and all three enable bits are 0.
- R2: A 0-to-1 transition on req_i[k], sampled at a clock edge, makes line k pending from that edge on. The line stays pending after req_i[k] falls. A line held high does not become pending again after it is cleared.
- R3: Writing the level register (wr_sel_i=0) loads the threshold from wr_data_i[2:0] and the mode from wr_data_i[3]. In compare mode (bit 3 = 0), line k may interrupt only if k < threshold.
- R4: In priority mode (wr_data_i[3] = 1), the threshold has no effect on which lines may interrupt.
- R5: Writing the enable register (wr_sel_i=1) loads wr_data_i[2:0]. Bit k enables line k for k = 0, 1, 2, and 1 means enabled. Lines 3 to 7 are never gated by this register.
- R6: irq_o is high, combinationally, exactly when some pending line passes both the enable gate and the threshold gate. irq_lvl_o then shows the lowest-numbered such line. While irq_o is low, irq_lvl_o is 0.
- R7: When ack_i is high at a clock edge while irq_o is high, only the line shown on irq_lvl_o is cleared.
- R8: The same acknowledge loads the threshold with the acknowledged line number. The mode bit is unchanged.
- R9: When ack_i is high while irq_o is low, the threshold and the pending lines do not change.
- R10: If a level-register write and an acknowledge fall on the same edge, the written value wins for the level register. The reported line is still cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Request lines; bit k is priority k (0 is highest) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the level register, 1 selects the enable register |
| wr_data_i | input | 8 | Write data |
| ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_lvl_o | output | 3 | Number of the winning line |

## Verification
The assertions check the following on every cycle:
- the reported line always lies below the threshold in compare mode;
- an internal line is reported only when its enable bit is set;
- a quiet output carries code 0;
- a fresh edge raises the interrupt in priority mode on the next cycle;
- an acknowledge in compare mode leaves only higher priorities able to interrupt;
- an acknowledge with no interrupt leaves the threshold unchanged.

Some behaviours are visible only through the bench's cycle-by-cycle scenarios:
- pending state surviving a falling request;
- no relatch while a line is held high;
- exactly which line an acknowledge clears;
- the write that wins over a simultaneous acknowledge.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned NUM_SRC    = 8;
  localparam int unsigned LVL_W      = $clog2(NUM_SRC);
  localparam int unsigned NUM_GATED  = 3;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned MODE_BIT   = LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic {
    MODE_CMP  = 1'b0,
    MODE_PRIO = 1'b1
  } lvl_mode_e;
endpackage

// File: rtl/lvl_irq_edge.sv
module lvl_irq_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] rise;

  assign rise = req_i & ~req_q;

  // a new edge takes precedence over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_fire_i,
  input  lvl_t              ack_lvl_i,
  output lvl_t              thr_o,
  output lvl_mode_e         mode_o,
  output logic [NUM_GATED-1:0] en_o
);
  logic wr_lvl, wr_en_reg;

  assign wr_lvl    = wr_en_i & ~wr_sel_i;
  assign wr_en_reg = wr_en_i &  wr_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o  <= '0;
      mode_o <= MODE_CMP;
    end else if (wr_lvl) begin
      thr_o  <= wr_data_i[LVL_W-1:0];
      mode_o <= lvl_mode_e'(wr_data_i[MODE_BIT]);
    end else if (ack_fire_i) begin
      thr_o  <= ack_lvl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_o <= '0;
    else if (wr_en_reg) en_o <= wr_data_i[NUM_GATED-1:0];
  end
endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb
  import lvl_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0]   pend_i,
  input  logic [NUM_GATED-1:0] en_i,
  input  lvl_t                 thr_i,
  input  lvl_mode_e            mode_i,
  output logic                 irq_o,
  output lvl_t                 lvl_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic gate_en, gate_thr;
    if (g < NUM_GATED) begin : g_gated
      assign gate_en = en_i[g];
    end else begin : g_free
      assign gate_en = 1'b1;
    end
    assign gate_thr = (mode_i == MODE_PRIO) || (lvl_t'(g) < thr_i);
    assign elig[g]  = pend_i[g] & gate_en & gate_thr;
  end

  always_comb begin
    lvl_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) lvl_o = lvl_t'(i);
    end
  end

  assign irq_o = |elig;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_lvl_o
);
  logic [NUM_SRC-1:0]   pend;
  logic [NUM_SRC-1:0]   clr;
  logic [NUM_GATED-1:0] en_q;
  lvl_t                 thr_q;
  lvl_mode_e            mode_q;
  logic                 ack_fire;

  assign ack_fire = ack_i & irq_o;
  assign clr      = ack_fire ? (NUM_SRC'(1) << irq_lvl_o) : '0;

  lvl_irq_edge #(.N(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  lvl_irq_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .ack_fire_i (ack_fire),
    .ack_lvl_i  (irq_lvl_o),
    .thr_o      (thr_q),
    .mode_o     (mode_q),
    .en_o       (en_q)
  );

  lvl_irq_arb u_arb (
    .pend_i (pend),
    .en_i   (en_q),
    .thr_i  (thr_q),
    .mode_i (mode_q),
    .irq_o  (irq_o),
    .lvl_o  (irq_lvl_o)
  );
endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk
  import lvl_irq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_SRC-1:0]   req_i,
  input logic                 wr_en_i,
  input logic                 ack_i,
  input logic                 irq_o,
  input logic [LVL_W-1:0]     irq_lvl_o,
  input logic [LVL_W-1:0]     thr_q,
  input logic                 mode_q,
  input logic [NUM_GATED-1:0] en_q
);
  p_idle_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> irq_lvl_o == '0);

  p_below_thr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !mode_q) |-> irq_lvl_o < thr_q);

  p_gated_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_lvl_o < LVL_W'(NUM_GATED))
      |-> |(en_q & (NUM_GATED'(1) << irq_lvl_o)));

  p_edge_raises_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(req_i[NUM_SRC-1]) && mode_q && !wr_en_i) |=> irq_o);

  p_ack_narrows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !wr_en_i && !mode_q)
      |=> (!irq_o || irq_lvl_o < $past(irq_lvl_o)));

  p_idle_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !wr_en_i) |=> $stable(thr_q));
endmodule

bind lvl_irq_ctrl lvl_irq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .wr_en_i   (wr_en_i),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .irq_lvl_o (irq_lvl_o),
  .thr_q     (thr_q),
  .mode_q    (mode_q),
  .en_q      (en_q)
);

// File: tb/lvl_irq_ctrl_bench.sv
module lvl_irq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [2:0] irq_lvl_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic       irq;
    logic [2:0] lvl;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk_i, .rst_ni, .req_i, .wr_en_i, .wr_sel_i, .wr_data_i, .ack_i,
    .irq_o, .irq_lvl_o
  );

  // driver: one cycle of stimulus and the result expected after the next edge
  task automatic step(input logic [7:0] req, input logic we, input logic sel,
                      input logic [7:0] d, input logic ack,
                      input logic e_irq, input logic [2:0] e_lvl, input string tag);
    @(negedge clk_i);
    req_i = req; wr_en_i = we; wr_sel_i = sel; wr_data_i = d; ack_i = ack;
    exp_q.push_back('{e_irq, e_lvl, tag});
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (irq_o !== e.irq || irq_lvl_o !== e.lvl) begin
        bad++;
        $display("FAIL %s: irq=%b lvl=%0d expected irq=%b lvl=%0d",
                 e.tag, irq_o, irq_lvl_o, e.irq, e.lvl);
      end
    end
  end

  initial begin
    #1;
    total++;
    if (irq_o !== 1'b0 || irq_lvl_o !== 3'd0) begin
      bad++;
      $display("FAIL R1 in reset: irq=%b lvl=%0d expected irq=0 lvl=0", irq_o, irq_lvl_o);
    end
    #11 rst_ni = 1'b1;
    step(8'h00, 0, 0, 8'h00, 0, 0, 3'd0, "R1 idle after reset");
    step(8'h80, 0, 0, 8'h00, 0, 0, 3'd0, "R3 threshold 0 blocks line 7");
    step(8'h80, 1, 0, 8'h08, 0, 1, 3'd7, "R4 priority mode passes line 7");
    step(8'h80, 1, 0, 8'h07, 0, 0, 3'd0, "R3 threshold 7 blocks line 7");
    step(8'h00, 0, 0, 8'h00, 0, 0, 3'd0, "R3 line 7 still blocked");
    step(8'h00, 1, 0, 8'h08, 0, 1, 3'd7, "R2 pending kept after fall");
    step(8'h01, 0, 0, 8'h00, 0, 1, 3'd7, "R5 line 0 disabled");
    step(8'h01, 1, 1, 8'h01, 0, 1, 3'd0, "R5 R6 line 0 enabled wins");
    step(8'h01, 0, 0, 8'h00, 1, 1, 3'd7, "R7 ack clears only line 0");
    step(8'h01, 0, 0, 8'h00, 1, 0, 3'd0, "R7 R2 ack clears 7, held line 0 not relatched");
    step(8'h00, 0, 0, 8'h00, 0, 0, 3'd0, "R6 idle");
    step(8'h30, 1, 0, 8'h05, 0, 1, 3'd4, "R3 R6 threshold 5 passes line 4");
    step(8'h30, 0, 0, 8'h00, 1, 0, 3'd0, "R8 ack loads threshold 4, line 5 blocked");
    step(8'h30, 0, 0, 8'h00, 1, 0, 3'd0, "R9 ack while idle");
    step(8'h30, 1, 0, 8'h06, 0, 1, 3'd5, "R9 line 5 still pending");
    step(8'h34, 0, 0, 8'h00, 0, 1, 3'd5, "R5 timer line disabled");
    step(8'h34, 1, 1, 8'h04, 0, 1, 3'd2, "R5 timer line enabled");
    step(8'h34, 1, 0, 8'h08, 1, 1, 3'd5, "R10 write wins over ack");
    step(8'h34, 0, 0, 8'h00, 1, 0, 3'd0, "R7 ack clears line 5");
    step(8'h08, 1, 1, 8'h00, 0, 1, 3'd3, "R5 line 3 ungated");
    step(8'h08, 0, 0, 8'h00, 0, 1, 3'd3, "R6 line 3 held");
    @(negedge clk_i);
    ack_i = 1'b0; wr_en_i = 1'b0;
    repeat (3) @(posedge clk_i);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule